// File: doc/BRIEF.md
# Vector Strip-Mining Length Sequencer

This block splits a vector operation of arbitrary element count into pieces that each fit the machine's maximum vector length (MVL). For every piece it hands out a descriptor that holds three things: the index of the first element, the value to load into the vector-length register, and the base addresses of two operand streams for that piece. It does not execute the operation, touch memory or compute on elements. It only sets the piece boundaries.

The short, odd-sized piece goes first and every later piece is a full MVL. This lets the loop body that follows always run at full length. When the count is an exact multiple of MVL, no empty piece is issued. A start pulse that arrives while the block is idle loads the element count and both stream bases. Descriptors then leave one at a time over a valid/ready handshake. A single-cycle done pulse marks the end of the sequence.

The controller has three states:
- `ST_IDLE` waits for start. It moves to `ST_ISSUE` when the count is non-zero and straight to `ST_WRAP` when the count is zero.
- `ST_ISSUE` offers descriptors. It stays there after each accepted descriptor while pieces remain, and moves to `ST_WRAP` on the handshake of the last piece.
- `ST_WRAP` raises done for one cycle and always returns to `ST_IDLE`.

Top module: `vsm_strip_seq`

## Requirements
- R1: After reset, and while reset is held, `strip_valid`, `done` and `busy` are 0.
- R2: `start` is accepted only while `busy` is 0. A `start` while busy changes neither the sequence in progress nor its addresses.
- R3: For a non-zero count n, the first descriptor appears in the cycle after `start` with `strip_start` = 0 and `strip_len` = n mod MVL (MVL = 64 by default), or MVL when that remainder is 0.
- R4: Every descriptor after the first has `strip_len` = MVL. Its `strip_start` equals the previous descriptor's `strip_start` plus the previous `strip_len`.
- R5: When n is a non-zero multiple of MVL, no zero-length descriptor is issued, and exactly n/MVL descriptors of length MVL are issued.
- R6: n = 0 issues no descriptor, and `done` is 1 in the cycle right after the `start` cycle.
- R7: Exactly ceil(n/MVL) descriptors are accepted. `done` is a one-cycle pulse in the cycle after the last handshake, and `strip_valid` is 0 while `done` is 1.
- R8: While `strip_valid` is 1 and `strip_ready` is 0, the descriptor (`strip_start`, `strip_len`, both addresses) and `strip_valid` stay unchanged into the next cycle.
- R9: `strip_addr_a` = base_a + `strip_start` × ELEM_BYTES, and `strip_addr_b` likewise from base_b, using the bases captured at the accepted `start`. The default ELEM_BYTES is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (honoured only when idle) |
| n_elems | input | N_W | Total element count of the operation |
| base_a | input | ADDR_W | Byte base address of operand stream A |
| base_b | input | ADDR_W | Byte base address of operand stream B |
| busy | output | 1 | A sequence is in progress |
| strip_valid | output | 1 | Descriptor on the strip outputs is valid |
| strip_ready | input | 1 | Consumer accepts the descriptor |
| strip_start | output | N_W | First element index of the strip |
| strip_len | output | clog2(MVL)+1 | Vector length of the strip |
| strip_addr_a | output | ADDR_W | Stream A byte address of the strip's first element |
| strip_addr_b | output | ADDR_W | Stream B byte address of the strip's first element |
| done | output | 1 | One-cycle pulse after the final strip |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Counts on either side of multiples of MVL (63, 64, 65, 128, 129).** A design that issued the remainder last would report a first length of 64 where 1 is due. One that did not suppress the empty piece would issue a zero length, or one descriptor too many.
- **n = 0.** A design that entered the issue state anyway would raise valid, or would delay done.
- **Consumer back-pressure.** A design that advanced on valid alone would drift in its start index or show a changing descriptor.
- **A stray start while busy, and a reset in mid-sequence.** A design that reloaded on the stray start would restart from a wrong count.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WRAP  = 2'd2
    } vsm_state_e;

endpackage

// File: rtl/vsm_strip_plan.sv
// Derives the first piece's length and the number of full pieces that follow
// it from the total element count. MVL must be a power of two.
module vsm_strip_plan #(
    parameter int MVL = 64,
    parameter int N_W = 16
) (
    input  logic [N_W-1:0]            n_elems,
    output logic [$clog2(MVL):0]      first_len,
    output logic [N_W-1:0]            extra_strips,
    output logic                      empty
);
    localparam int LOG_MVL = $clog2(MVL);
    localparam int LEN_W   = LOG_MVL + 1;

    logic [LOG_MVL-1:0] rem;
    logic [N_W-1:0]     full_cnt;

    assign rem      = n_elems[LOG_MVL-1:0];
    assign full_cnt = n_elems >> LOG_MVL;
    assign empty    = (n_elems == '0);

    always_comb begin
        if (rem == '0) begin
            // exact multiple: the first piece is already a full one
            first_len    = LEN_W'(MVL);
            extra_strips = full_cnt - N_W'(1);
        end else begin
            first_len    = {1'b0, rem};
            extra_strips = full_cnt;
        end
    end
endmodule

// File: rtl/vsm_stream_addr.sv
// One operand stream: captures its base at sequence start and offsets it by
// the current element index scaled to bytes.
module vsm_stream_addr #(
    parameter int N_W        = 16,
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [N_W-1:0]    elem_idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int LOG_EB = $clog2(ELEM_BYTES);

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load) begin
            base_q <= base_in;
        end
    end

    assign addr = base_q + (ADDR_W'(elem_idx) << LOG_EB);
endmodule

// File: rtl/vsm_strip_seq.sv
module vsm_strip_seq
    import vsm_pkg::*;
#(
    parameter int MVL        = 64,
    parameter int N_W        = 16,
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [N_W-1:0]        n_elems,
    input  logic [ADDR_W-1:0]     base_a,
    input  logic [ADDR_W-1:0]     base_b,
    output logic                  busy,
    output logic                  strip_valid,
    input  logic                  strip_ready,
    output logic [N_W-1:0]        strip_start,
    output logic [$clog2(MVL):0]  strip_len,
    output logic [ADDR_W-1:0]     strip_addr_a,
    output logic [ADDR_W-1:0]     strip_addr_b,
    output logic                  done
);
    localparam int LOG_MVL  = $clog2(MVL);
    localparam int LEN_W    = LOG_MVL + 1;
    localparam int NUM_STRM = 2;

    vsm_state_e state_q, state_d;

    logic [N_W-1:0]   idx_q;
    logic [LEN_W-1:0] len_q;
    logic [N_W-1:0]   left_q;

    logic [LEN_W-1:0] plan_first_len;
    logic [N_W-1:0]   plan_extra;
    logic             plan_empty;

    logic accept;
    logic xfer;
    logic last_strip;

    vsm_strip_plan #(
        .MVL (MVL),
        .N_W (N_W)
    ) u_plan (
        .n_elems      (n_elems),
        .first_len    (plan_first_len),
        .extra_strips (plan_extra),
        .empty        (plan_empty)
    );

    assign accept     = start && (state_q == ST_IDLE);
    assign xfer       = strip_valid && strip_ready;
    assign last_strip = (left_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = plan_empty ? ST_WRAP : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (xfer && last_strip) begin
                    state_d = ST_WRAP;
                end
            end
            ST_WRAP: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // strip bookkeeping: index, current length, pieces remaining after this one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            len_q  <= '0;
            left_q <= '0;
        end else if (accept) begin
            idx_q  <= '0;
            len_q  <= plan_first_len;
            left_q <= plan_extra;
        end else if (xfer && !last_strip) begin
            idx_q  <= idx_q + N_W'(len_q);
            len_q  <= LEN_W'(MVL);
            left_q <= left_q - N_W'(1);
        end
    end

    // outputs decoded from state
    always_comb begin
        busy        = 1'b0;
        strip_valid = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_ISSUE: begin
                busy        = 1'b1;
                strip_valid = 1'b1;
            end
            ST_WRAP: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign strip_start = idx_q;
    assign strip_len   = len_q;

    // operand stream address generators
    logic [ADDR_W-1:0] strm_base [NUM_STRM];
    logic [ADDR_W-1:0] strm_addr [NUM_STRM];

    assign strm_base[0] = base_a;
    assign strm_base[1] = base_b;

    for (genvar g = 0; g < NUM_STRM; g++) begin : g_strm
        vsm_stream_addr #(
            .N_W        (N_W),
            .ADDR_W     (ADDR_W),
            .ELEM_BYTES (ELEM_BYTES)
        ) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept),
            .base_in  (strm_base[g]),
            .elem_idx (idx_q),
            .addr     (strm_addr[g])
        );
    end

    assign strip_addr_a = strm_addr[0];
    assign strip_addr_b = strm_addr[1];
endmodule

// File: rtl/vsm_strip_seq_chk.sv
module vsm_strip_seq_chk #(
    parameter int MVL        = 64,
    parameter int N_W        = 16,
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic [N_W-1:0]        n_elems,
    input logic                  busy,
    input logic                  strip_valid,
    input logic                  strip_ready,
    input logic [N_W-1:0]        strip_start,
    input logic [$clog2(MVL):0]  strip_len,
    input logic [ADDR_W-1:0]     strip_addr_a,
    input logic [ADDR_W-1:0]     strip_addr_b,
    input logic                  done
);
    localparam int LEN_W = $clog2(MVL) + 1;

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!strip_valid && !done && !busy));

    a_r3_first_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && n_elems != '0) |=> (strip_valid && strip_start == '0));

    a_r4_full_after_first: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid && strip_ready) |=> (done || strip_len == LEN_W'(MVL)));

    a_r4_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid && strip_ready) |=>
            (done || strip_start == $past(strip_start) + N_W'($past(strip_len))));

    a_r5_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        strip_valid |-> (strip_len != '0 && strip_len <= LEN_W'(MVL)));

    a_r6_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && n_elems == '0) |=> (done && !strip_valid));

    a_r7_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !strip_valid);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid && !strip_ready) |=>
            (strip_valid && $stable(strip_start) && $stable(strip_len)
             && $stable(strip_addr_a) && $stable(strip_addr_b)));

    a_r9_addr_a_step: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid && strip_ready) |=>
            (done || strip_addr_a == $past(strip_addr_a)
                + ADDR_W'($past(strip_len)) * ADDR_W'(ELEM_BYTES)));

    a_r9_addr_b_step: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid && strip_ready) |=>
            (done || strip_addr_b == $past(strip_addr_b)
                + ADDR_W'($past(strip_len)) * ADDR_W'(ELEM_BYTES)));
endmodule

bind vsm_strip_seq vsm_strip_seq_chk #(
    .MVL        (MVL),
    .N_W        (N_W),
    .ADDR_W     (ADDR_W),
    .ELEM_BYTES (ELEM_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .n_elems      (n_elems),
    .busy         (busy),
    .strip_valid  (strip_valid),
    .strip_ready  (strip_ready),
    .strip_start  (strip_start),
    .strip_len    (strip_len),
    .strip_addr_a (strip_addr_a),
    .strip_addr_b (strip_addr_b),
    .done         (done)
);

// File: tb/vsm_strip_seq_tb.sv
module vsm_strip_seq_tb;
    localparam int MVL    = 64;
    localparam int N_W    = 16;
    localparam int ADDR_W = 32;
    localparam int EB     = 8;
    localparam int LEN_W  = $clog2(MVL) + 1;

    localparam int NV = 8;
    localparam int TAB_N     [NV] = '{1, 63, 64, 65, 127, 128, 129, 1000};
    localparam int TAB_CNT   [NV] = '{1,  1,  1,  2,   2,   2,   3,   16};
    localparam int TAB_FIRST [NV] = '{1, 63, 64,  1,  63,  64,   1,   40};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [N_W-1:0]    n_elems = '0;
    logic [ADDR_W-1:0] base_a = '0;
    logic [ADDR_W-1:0] base_b = '0;
    logic              busy;
    logic              strip_valid;
    logic              strip_ready = 1'b0;
    logic [N_W-1:0]    strip_start;
    logic [LEN_W-1:0]  strip_len;
    logic [ADDR_W-1:0] strip_addr_a;
    logic [ADDR_W-1:0] strip_addr_b;
    logic              done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    vsm_strip_seq #(.MVL(MVL), .N_W(N_W), .ADDR_W(ADDR_W), .ELEM_BYTES(EB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_elems(n_elems),
        .base_a(base_a), .base_b(base_b), .busy(busy),
        .strip_valid(strip_valid), .strip_ready(strip_ready),
        .strip_start(strip_start), .strip_len(strip_len),
        .strip_addr_a(strip_addr_a), .strip_addr_b(strip_addr_b), .done(done)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fails = n_fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drives one sequence and compares it strip by strip against a software
    // model of the remainder-first loop. mode picks the ready pattern.
    task automatic run_op(input int n, input int mode, input bit stray,
                          output int got_cnt, output int got_first);
        int exp_cnt;
        int exp_start;
        int exp_len;
        logic [ADDR_W-1:0] ba;
        logic [ADDR_W-1:0] bb;
        bit expect_done;
        bit hold;
        logic [N_W-1:0]    h_start;
        logic [LEN_W-1:0]  h_len;
        logic [ADDR_W-1:0] h_a;
        bit rdy;
        exp_cnt   = (n + MVL - 1) / MVL;
        exp_start = 0;
        exp_len   = (n % MVL == 0) ? MVL : n % MVL;
        ba = 32'h1000_0000 + ADDR_W'(n * 16);
        bb = 32'h2000_0000 + ADDR_W'(n * 8);
        got_cnt = 0;
        got_first = -1;
        expect_done = (n == 0);
        hold = 1'b0;
        @(negedge clk);
        n_elems = N_W'(n);
        base_a = ba;
        base_b = bb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (stray && cyc == 1) begin
                start = 1'b1;
                n_elems = N_W'(5);
                base_a = 32'h7777_0000;
            end else begin
                start = 1'b0;
            end
            if (hold) begin
                chk(strip_valid && strip_start == h_start && strip_len == h_len
                    && strip_addr_a == h_a, "R8", "held descriptor start",
                    strip_start, h_start);
            end
            if (expect_done) begin
                chk(done == 1'b1, (n == 0) ? "R6" : "R7", "done after last strip", done, 1);
            end
            if (done) begin
                chk(got_cnt == exp_cnt, "R7", "strip count", got_cnt, exp_cnt);
                chk(!strip_valid, "R7", "valid during done", strip_valid, 0);
                break;
            end
            rdy = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : (cyc % 3 != 0);
            strip_ready = rdy;
            hold = 1'b0;
            if (strip_valid) begin
                if (rdy) begin
                    got_cnt = got_cnt + 1;
                    if (got_cnt == 1) got_first = int'(strip_len);
                    chk(got_cnt <= exp_cnt, "R7", "extra strip", got_cnt, exp_cnt);
                    chk(int'(strip_start) == exp_start, (got_cnt == 1) ? "R3" : "R4",
                        "strip start", strip_start, exp_start);
                    chk(int'(strip_len) == exp_len,
                        (got_cnt == 1) ? "R3" : ((n % MVL == 0) ? "R5" : "R4"),
                        "strip len", strip_len, exp_len);
                    chk(strip_addr_a == ba + ADDR_W'(exp_start * EB), "R9", "addr a",
                        strip_addr_a, ba + ADDR_W'(exp_start * EB));
                    chk(strip_addr_b == bb + ADDR_W'(exp_start * EB), "R9", "addr b",
                        strip_addr_b, bb + ADDR_W'(exp_start * EB));
                    exp_start = exp_start + exp_len;
                    exp_len = MVL;
                    expect_done = (got_cnt == exp_cnt);
                end else begin
                    hold = 1'b1;
                    h_start = strip_start;
                    h_len = strip_len;
                    h_a = strip_addr_a;
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        strip_ready = 1'b0;
    endtask

    initial begin
        int cnt;
        int first;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!strip_valid && !done && !busy, "R1", "outputs in reset",
            {strip_valid, done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!strip_valid && !done && !busy, "R1", "outputs after reset",
            {strip_valid, done, busy}, 0);

        // table of boundary counts
        for (int i = 0; i < NV; i++) begin
            run_op(TAB_N[i], i % 3, 1'b0, cnt, first);
            chk(cnt == TAB_CNT[i], "R7", "table strip count", cnt, TAB_CNT[i]);
            chk(first == TAB_FIRST[i], (TAB_N[i] % MVL == 0) ? "R5" : "R3",
                "table first len", first, TAB_FIRST[i]);
        end

        // sweep against the loop model, R3 R4 R5 R6 R7 R9
        for (int n = 0; n <= 300; n++) begin
            run_op(n, n % 3, 1'b0, cnt, first);
        end

        // R6: zero count directed
        run_op(0, 0, 1'b0, cnt, first);
        chk(cnt == 0, "R6", "no strips for zero", cnt, 0);

        // R2: stray start while busy under back-pressure
        run_op(130, 1, 1'b1, cnt, first);
        chk(first == 2, "R2", "first len unaffected by stray start", first, 2);
        chk(cnt == 3, "R2", "count unaffected by stray start", cnt, 3);

        // R1: reset in mid-sequence
        @(negedge clk);
        n_elems = N_W'(200);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        strip_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!strip_valid && !done && !busy, "R1", "mid-run reset",
            {strip_valid, done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(70, 0, 1'b0, cnt, first);
        chk(first == 6 && cnt == 2, "R1", "recovery after reset first len", first, 6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule